// File: doc/BRIEF.md
# Absolute-deadline interrupt timer

The block keeps a 64-bit time-stamp counter that advances by one on every clock. It also holds a timer control register and a 64-bit deadline register. Software selects deadline mode in the control register, picks an interrupt vector and optionally masks the request. It then writes an absolute counter value into the deadline register. When the counter is at or beyond that value, the block raises a single-cycle interrupt request together with the vector. In the same step it zeroes the deadline, so each programmed deadline yields at most one request.

A deadline that already lies in the past, or equals the current count, is not lost: the compare succeeds on the next clock edge and the request follows at once. Writing zero to the deadline register disarms the timer. Outside deadline mode the deadline register ignores writes and reads as zero.

Top module: `dl_timer`

## Requirements
- R1: After reset the control register and the deadline register read zero, the request output is low and the counter is zero.
- R2: The counter output increases by exactly one per clock cycle.
- R3: The control register is at address 0 and the deadline register at address 1. In the control register, bits 7:0 hold the vector, bit 16 is the mask, and bits 18:17 are the mode, where 2 means deadline mode. All other bits read as zero, so writing all ones reads back 0x0007_00FF. Vector 0xEF is accepted.
- R4: For a nonzero deadline D written in deadline mode, the request is high in the cycle after the first clock edge at which the counter is at least D. The register holds D from the write edge onward. If the write edge moves the counter from T to T+1 and D > T+1, the request is observed while the counter reads D+1.
- R5: A deadline at or below the count on the cycle after its write fires on the next edge. With the write edge moving the counter from T to T+1 and 0 < D <= T+1, the request is observed while the counter reads T+2.
- R6: Each armed deadline produces exactly one request, lasting one cycle. The vector output shows the programmed vector in that same cycle.
- R7: After the deadline expires, the deadline register reads zero.
- R8: Writing zero to the deadline register disarms the timer, including a pending future deadline, and no request follows.
- R9: While the mask bit is set, expiry still clears the deadline but no request is issued.
- R10: When the mode is not 2, deadline writes are ignored and the deadline reads zero. Writing the control register with a mode other than 2 discards an armed deadline, and no request follows.
- R11: Rewriting the deadline before expiry replaces the old value, and only the new deadline produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 deadline |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the selected register, combinational |
| tsc_o | output | 64 | Current time-stamp counter |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector presented with the request |

## Verification
The bench sweeps the deadline across offsets from a few counts in the past to a dozen in the future. It predicts the exact counter value at which the request must appear. An off-by-one in the compare, such as using greater-than instead of greater-or-equal, would show up as a request one count late, and a past deadline that is never caught would show up as no request at all. Each case also counts pulses and reads the deadline back, which exposes a request that repeats or a deadline that does not clear itself. Further cases write zero, change the mode, set the mask and rewrite a pending deadline. A design that arms from zero, keeps a deadline across a mode change, or lets the mask also block the clearing would produce a stray request or a non-zero readback in these cases.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = 17;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             mask;
    tmr_mode_e        mode;
  } ctrl_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DL   = 1'b1;
endpackage

// File: rtl/dlt_counter.sv
module dlt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dlt_regs.sv
module dlt_regs
  import dlt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             fire_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] dl_o,
  output logic             dl_we_o,
  output logic [CNT_W-1:0] rdata_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] dl_q, dl_d;
  logic             ctrl_we;
  logic             dl_we;
  logic [CNT_W-1:0] rd_ctrl;

  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);
  // deadline writes only land in deadline mode
  assign dl_we   = we_i && (addr_i == ADDR_DL) && (ctrl_q.mode == MODE_DEADLINE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.vec  = wdata_i[VEC_W-1:0];
      ctrl_d.mask = wdata_i[MASK_BIT];
      ctrl_d.mode = tmr_mode_e'(wdata_i[MODE_LSB +: MODE_W]);
    end
  end

  always_comb begin
    dl_d = dl_q;
    if (fire_i) dl_d = '0;
    if (dl_we)  dl_d = wdata_i;
    if (ctrl_we && (ctrl_d.mode != MODE_DEADLINE)) dl_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dl_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dl_q   <= dl_d;
    end
  end

  always_comb begin
    rd_ctrl = '0;
    rd_ctrl[VEC_W-1:0]          = ctrl_q.vec;
    rd_ctrl[MASK_BIT]           = ctrl_q.mask;
    rd_ctrl[MODE_LSB +: MODE_W] = ctrl_q.mode;
  end

  assign rdata_o = (addr_i == ADDR_CTRL) ? rd_ctrl
                 : ((ctrl_q.mode == MODE_DEADLINE) ? dl_q : '0);
  assign ctrl_o  = ctrl_q;
  assign dl_o    = dl_q;
  assign dl_we_o = dl_we;
endmodule

// File: rtl/dlt_fire.sv
module dlt_fire
  import dlt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dl_i,
  input  ctrl_t            ctrl_i,
  output logic             fire_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             armed;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  assign armed  = (ctrl_i.mode == MODE_DEADLINE) && (dl_i != '0);
  // at-or-past compare: a stale deadline fires on the next edge
  assign fire_o = armed && (cnt_i >= dl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= fire_o && !ctrl_i.mask;
      if (fire_o) vec_q <= ctrl_i.vec;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/dl_timer.sv
module dl_timer
  import dlt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic                     reg_addr_i,
  input  logic [CNT_W-1:0]         reg_wdata_i,
  output logic [CNT_W-1:0]         reg_rdata_o,
  output logic [CNT_W-1:0]         tsc_o,
  output logic                     irq_o,
  output logic [dlt_pkg::VEC_W-1:0] irq_vec_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dl_q;
  ctrl_t            ctrl_q;
  logic             fire;
  logic             dl_we;

  dlt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  dlt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .fire_i (fire),
    .ctrl_o (ctrl_q),
    .dl_o   (dl_q),
    .dl_we_o(dl_we),
    .rdata_o(reg_rdata_o)
  );

  dlt_fire #(.CNT_W(CNT_W)) u_fire (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .dl_i  (dl_q),
    .ctrl_i(ctrl_q),
    .fire_o(fire),
    .irq_o (irq_o),
    .vec_o (irq_vec_o)
  );

  assign tsc_o = cnt;
endmodule

// File: rtl/dlt_checker.sv
module dlt_checker
  import dlt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tsc_o,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [CNT_W-1:0] dl_q,
  input ctrl_t            ctrl_q,
  input logic             dl_we
);
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> tsc_o == $past(tsc_o) + 1'b1);

  p_expire_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode == MODE_DEADLINE && dl_q != '0 && tsc_o >= dl_q && !dl_we)
      |=> dl_q == '0);

  p_expire_raises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode == MODE_DEADLINE && dl_q != '0 && tsc_o >= dl_q && !ctrl_q.mask)
      |=> irq_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !dl_we) |=> !irq_o);

  p_vec_with_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_vec_o == $past(ctrl_q.vec));

  p_mask_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(ctrl_q.mask));

  p_mode_holds_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode != MODE_DEADLINE) |-> dl_q == '0);
endmodule

bind dl_timer dlt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tsc_o    (tsc_o),
  .irq_o    (irq_o),
  .irq_vec_o(irq_vec_o),
  .dl_q     (dl_q),
  .ctrl_q   (ctrl_q),
  .dl_we    (dl_we)
);

// File: tb/sim_dl_timer.sv
module sim_dl_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic         addr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] tsc;
  logic         irq;
  logic [7:0]   vec;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dl_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tsc_o(tsc),
    .irq_o(irq), .irq_vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk_ctrl(input int mode, input bit mask,
                                           input logic [7:0] v);
    logic [W-1:0] c;
    c = '0;
    c[7:0] = v;
    c[16] = mask;
    c[18:17] = mode[1:0];
    return c;
  endfunction

  task automatic wr(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // writes deadline t+off; returns t (count before the write edge)
  task automatic arm(input longint off, output longint t);
    @(negedge clk);
    t = longint'(tsc);
    we = 1'b1; addr = 1'b1; wdata = W'(t + off);
    @(negedge clk);
    we = 1'b0;
  endtask

  // watch n negedges; count pulses, remember last count and vector
  task automatic watch(input int n, output int pulses, output longint at,
                       output logic [7:0] v);
    pulses = 0; at = -1; v = '0;
    for (int i = 0; i < n; i++) begin
      if (irq) begin
        pulses++;
        at = longint'(tsc);
        v = vec;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input longint off, input logic [7:0] v, input bit mask);
    longint t, d, exp_at, at;
    int p;
    logic [7:0] gv;
    logic [W-1:0] r;
    wr(1'b0, mk_ctrl(2, mask, v));
    arm(off, t);
    d = t + off;
    exp_at = ((d > t + 1) ? d : t + 1) + 1;
    watch(20, p, at, gv);
    if (mask) begin
      chk(p == 0, "R9", "masked pulse count", p, 0);
    end else begin
      chk(p == 1, "R6", "pulse count", p, 1);
      if (off > 1) chk(at == exp_at, "R4", "future fire count", at, exp_at);
      else         chk(at == exp_at, "R5", "past fire count", at, exp_at);
      chk(gv == v, "R6", "vector with request", gv, v);
    end
    rd(1'b1, r);
    chk(r == 0, mask ? "R9" : "R7", "deadline after expiry", r, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    longint t0, t1, t, at;
    int p;
    logic [7:0] gv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(1'b0, r); chk(r == 0, "R1", "ctrl after reset", r, 0);
    rd(1'b1, r); chk(r == 0, "R1", "deadline after reset", r, 0);
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    chk(tsc == 1, "R1", "counter after reset", tsc, 1);

    // R2
    t0 = longint'(tsc);
    repeat (7) @(negedge clk);
    t1 = longint'(tsc);
    chk(t1 - t0 == 7, "R2", "counter step", t1 - t0, 7);

    // R3
    wr(1'b0, '1);
    rd(1'b0, r); chk(r == 64'h0007_00FF, "R3", "ctrl field mask", r, 64'h0007_00FF);
    wr(1'b0, mk_ctrl(2, 1'b0, 8'hEF));
    rd(1'b0, r); chk(r == 64'h0004_00EF, "R3", "ctrl deadline mode vec EF", r, 64'h0004_00EF);
    repeat (10) @(negedge clk);

    // R4 / R5 / R6 / R7 sweep
    for (int off = -4; off <= 12; off++) begin
      logic [7:0] v8;
      v8 = (off == 0) ? 8'hEF : 8'(off * 37 + 5);
      run_case(longint'(off), v8, 1'b0);
    end
    // R9 masked sweep
    for (int off = -1; off <= 4; off++) run_case(longint'(off), 8'h33, 1'b1);

    // R4 readback while armed
    wr(1'b0, mk_ctrl(2, 1'b0, 8'h10));
    arm(400, t);
    rd(1'b1, r); chk(r == W'(t + 400), "R4", "deadline readback while armed", r, t + 400);

    // R8 disarm pending deadline
    wr(1'b1, '0);
    watch(30, p, at, gv);
    chk(p == 0, "R8", "no irq after zero write", p, 0);
    rd(1'b1, r); chk(r == 0, "R8", "deadline zero", r, 0);

    // R10 writes ignored outside deadline mode
    wr(1'b0, mk_ctrl(0, 1'b0, 8'h20));
    arm(3, t);
    rd(1'b1, r); chk(r == 0, "R10", "deadline ignored in mode 0", r, 0);
    watch(15, p, at, gv);
    chk(p == 0, "R10", "no irq in mode 0", p, 0);
    wr(1'b0, mk_ctrl(2, 1'b0, 8'h20));
    rd(1'b1, r); chk(r == 0, "R10", "nothing latched in mode 0", r, 0);
    // mode change discards armed deadline
    arm(12, t);
    wr(1'b0, mk_ctrl(1, 1'b0, 8'h20));
    wr(1'b0, mk_ctrl(2, 1'b0, 8'h20));
    rd(1'b1, r); chk(r == 0, "R10", "deadline dropped on mode change", r, 0);
    watch(25, p, at, gv);
    chk(p == 0, "R10", "no irq after mode change", p, 0);

    // R11 rewrite replaces pending deadline
    wr(1'b0, mk_ctrl(2, 1'b0, 8'h5A));
    arm(60, t);
    arm(5, t);
    watch(80, p, at, gv);
    chk(p == 1, "R11", "single irq after rewrite", p, 1);
    chk(at == t + 6, "R11", "fire count of new deadline", at, t + 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule